// File: doc/BRIEF.md
# Clock Control Register Block

This block is the software-visible register file of a chip clock controller. A host reaches it over a simple 32-bit peripheral bus. Each request is one cycle wide. It carries a select, a write flag, a byte address, an access size and write data. The block answers one cycle later with a ready pulse, read data and an error flag. No clock is generated here. The block keeps 27 configuration words, each with a fixed reset value:

- nine PLL control words;
- three bus-divider words;
- a DRAM setup word;
- a memory-bus reset word;
- two PLL settle-time words;
- nine PLL bias words;
- two tuning words.

Two pieces of hardware behaviour are modelled. First, a PLL control word reports lock once its enable has been set and a settle delay has passed. The delay is taken from a settle-time word. Second, the update flag in the DRAM setup word can never be stored as one. Accesses are checked in the same cycle they arrive. Requests at or above the out-of-range boundary are refused with an error. Misaligned or sub-word requests are also refused with an error.

Top module: `ccu_regblock`

## Requirements
- R1: After reset the words read back with these values.
  - PLL control words 0x000 and 0x020 read 0x00001000.
  - PLL control word 0x008 reads 0x00035514.
  - PLL control words 0x010, 0x018, 0x038 and 0x048 read 0x03006207.
  - PLL control words 0x028 and 0x044 read 0x00041811.
  - Bus-divider words 0x050, 0x054 and 0x058 read 0x00010000, 0x00001010 and 0x01000000.
  - DRAM setup word 0x0F4 reads 0; memory-bus reset word 0x0FC reads 0x80000000.
  - Settle-time words 0x200 and 0x204 read 0x000000FF.
  - Bias words sit at each PLL control offset plus 0x220. They read 0x08100200 (CPU), 0x81104000 (DDR at 0x240), 0x10100010 (0x248, 0x264), and 0x10100000 for the others.
  - Tuning words 0x250 and 0x260 read 0x0A101000 and 0x14880000.
- R2: Every cycle with the select high is followed one cycle later by exactly one ready pulse. That ready cycle carries the word at the read address, or zero for a write, a refused request or an unmapped address. No ready appears without a request.
- R3: A mapped word, written with a full aligned word access, reads back the written value except for the bits named in R6 to R8. An in-range offset below 0x308 that holds no word reads as zero without error, and writes to it are dropped.
- R4: A request at byte offset 0x308 or above is answered with the error flag and zero data, and a write there changes nothing.
- R5: A request with the address not a multiple of four, or an access size code other than 2 (size 0 = byte, 1 = half, 2 = word), is answered with the error flag. It changes no word.
- R6: Bit 16 of the DRAM setup word is stored as zero on every write, whatever value was written.
- R7: A write that sets bit 31 (enable) of a PLL control word whose enable was clear starts a settle delay D. D is the low byte of settle-time word 0x200 for PLLs at 0x000 to 0x020, and of 0x204 for the other four. Bit 28 (lock) reads one from D cycles after the write edge. D = 0 gives lock in the same word the write stores.
- R8: A write that clears bit 31 clears bit 28 in the stored word at once. The written value of bit 28 is ignored. A write that keeps bit 31 set on an enabled PLL neither restarts nor cancels its settle delay.
- R9: A synchronous active-high reset reloads every word, cancels pending settle delays and clears the response outputs in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address inside the window |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Response pulse, one cycle after a request |
| busErr | output | 1 | Request refused, valid with busReady |

## Verification
Full-word reads of all 27 words after reset separate the per-word reset values. Writes of all-ones and patterned data to mapped, unmapped and out-of-range offsets separate storage from dropping. Refused requests are followed by read-back to show no word moved. Enable writes are tried with settle delays of zero, five and 255, with a re-enable while counting and with a disable, so that the lock cycle is pinned to the exact edge. A mid-run reset during a pending count shows the delay is cancelled.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int NUM_REGS     = 27;
  localparam int NUM_PLL      = 9;
  localparam int IDX_W        = $clog2(NUM_REGS);
  localparam int PLL_SPLIT    = 5;   // PLLs below this use the first settle word
  localparam int IDX_DRAM     = 12;
  localparam int IDX_TIME0    = 14;
  localparam int IDX_TIME1    = 15;
  localparam int EN_BIT       = 31;
  localparam int LOCK_BIT     = 28;
  localparam int DRAM_UPD_BIT = 16;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } ccuStrobe_t;

  function automatic logic [11:0] pllOffset(input int j);
    case (j)
      0: return 12'h000;
      1: return 12'h008;
      2: return 12'h010;
      3: return 12'h018;
      4: return 12'h020;
      5: return 12'h028;
      6: return 12'h038;
      7: return 12'h044;
      default: return 12'h048;
    endcase
  endfunction

  function automatic logic [11:0] regOffset(input int i);
    if (i < NUM_PLL) return pllOffset(i);
    if (i >= 16 && i < 16 + NUM_PLL) return pllOffset(i - 16) + 12'h220;
    case (i)
      9:  return 12'h050;
      10: return 12'h054;
      11: return 12'h058;
      12: return 12'h0F4;
      13: return 12'h0FC;
      14: return 12'h200;
      15: return 12'h204;
      25: return 12'h250;
      default: return 12'h260;
    endcase
  endfunction

  function automatic logic [31:0] regReset(input int i);
    case (i)
      0, 4:          return 32'h0000_1000;
      1:             return 32'h0003_5514;
      2, 3, 6, 8:    return 32'h0300_6207;
      5, 7:          return 32'h0004_1811;
      9:             return 32'h0001_0000;
      10:            return 32'h0000_1010;
      11:            return 32'h0100_0000;
      12:            return 32'h0000_0000;
      13:            return 32'h8000_0000;
      14, 15:        return 32'h0000_00FF;
      16:            return 32'h0810_0200;
      20:            return 32'h8110_4000;
      21, 23:        return 32'h1010_0010;
      25:            return 32'h0A10_1000;
      26:            return 32'h1488_0000;
      default:       return 32'h1010_0000;
    endcase
  endfunction
endpackage

// File: rtl/ccu_decode.sv
module ccu_decode
  import ccu_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOR_BASE = 'h308
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ccuStrobe_t        strobe,
  output logic              busReady,
  output logic              busErr
);
  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  logic             aligned;
  logic             inRange;
  logic             reqOk;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (busAddr == ADDR_W'(regOffset(i))) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign aligned = (busAddr[1:0] == 2'b00) && (busSize == SIZE_WORD);
  assign inRange = busAddr < OOR_BASE;
  assign reqOk   = aligned && inRange;

  assign strobe.wr  = busSel && busWrite && reqOk && hit;
  assign strobe.rd  = busSel && !busWrite && reqOk && hit;
  assign strobe.idx = hitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busReady <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      busReady <= busSel;
      busErr   <= busSel && !reqOk;
    end
  end
endmodule

// File: rtl/ccu_regfile.sv
module ccu_regfile
  import ccu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ccuStrobe_t         strobe,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_PLL-1:0] pllEn,
  output logic [NUM_PLL-1:0] pllLock,
  output logic               dramUpd
);
  logic [31:0] regQ   [NUM_REGS];
  logic [31:0] regD   [NUM_REGS];
  logic [7:0]  cntQ   [NUM_PLL];
  logic [7:0]  cntD   [NUM_PLL];
  logic [7:0]  pllDelay [NUM_PLL];
  logic [31:0] rdNext;

  // settle delay source per PLL
  always_comb begin
    for (int j = 0; j < NUM_PLL; j++) begin
      pllDelay[j] = (j < PLL_SPLIT) ? regQ[IDX_TIME0][7:0] : regQ[IDX_TIME1][7:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regD[i] = regQ[i];
    for (int j = 0; j < NUM_PLL; j++) begin
      cntD[j] = cntQ[j];
      if (cntQ[j] != 8'd0) begin
        cntD[j] = cntQ[j] - 8'd1;
        if (cntQ[j] == 8'd1) regD[j][LOCK_BIT] = 1'b1;
      end
      if (strobe.wr && strobe.idx == IDX_W'(j)) begin
        if (!wdata[EN_BIT]) begin
          regD[j]           = wdata;
          regD[j][LOCK_BIT] = 1'b0;
          cntD[j]           = 8'd0;
        end else if (!regQ[j][EN_BIT]) begin
          regD[j]           = wdata;
          regD[j][LOCK_BIT] = (pllDelay[j] == 8'd0);
          cntD[j]           = pllDelay[j];
        end else begin
          regD[j]           = {wdata[31:LOCK_BIT+1], regD[j][LOCK_BIT], wdata[LOCK_BIT-1:0]};
        end
      end
    end
    for (int i = NUM_PLL; i < NUM_REGS; i++) begin
      if (strobe.wr && strobe.idx == IDX_W'(i)) begin
        regD[i] = wdata;
        if (i == IDX_DRAM) regD[i][DRAM_UPD_BIT] = 1'b0;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.rd && strobe.idx == IDX_W'(i)) rdNext = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= regReset(i);
      for (int j = 0; j < NUM_PLL; j++) cntQ[j] <= 8'd0;
      rdata <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= regD[i];
      for (int j = 0; j < NUM_PLL; j++) cntQ[j] <= cntD[j];
      rdata <= rdNext;
    end
  end

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_status
    assign pllEn[g]   = regQ[g][EN_BIT];
    assign pllLock[g] = regQ[g][LOCK_BIT];
  end
  assign dramUpd = regQ[IDX_DRAM][DRAM_UPD_BIT];
endmodule

// File: rtl/ccu_regblock.sv
module ccu_regblock
  import ccu_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOR_BASE = 'h308
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              busErr
);
  ccuStrobe_t         strobe;
  logic [NUM_PLL-1:0] pllEn;
  logic [NUM_PLL-1:0] pllLock;
  logic               dramUpd;

  ccu_decode #(.ADDR_W(ADDR_W), .OOR_BASE(OOR_BASE)) u_decode (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .strobe(strobe),
    .busReady(busReady), .busErr(busErr)
  );

  ccu_regfile u_regfile (
    .clk(clk), .rst(rst), .strobe(strobe), .wdata(busWdata),
    .rdata(busRdata), .pllEn(pllEn), .pllLock(pllLock), .dramUpd(dramUpd)
  );
endmodule

// File: rtl/ccu_regblock_chk.sv
module ccu_regblock_chk
  import ccu_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOR_BASE = 'h308
) (
  input logic               clk,
  input logic               rst,
  input logic               busSel,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [1:0]         busSize,
  input logic [31:0]        busRdata,
  input logic               busReady,
  input logic               busErr,
  input logic [NUM_PLL-1:0] pllEn,
  input logic [NUM_PLL-1:0] pllLock,
  input logic               dramUpd
);
  p_ready_follows_r2: assert property (@(posedge clk) disable iff (rst) busSel |=> busReady);
  p_ready_quiet_r2:   assert property (@(posedge clk) disable iff (rst) !busSel |=> !busReady);
  p_err_zero_r4:      assert property (@(posedge clk) disable iff (rst) busErr |-> (busRdata == 32'd0));
  p_oor_err_r4:       assert property (@(posedge clk) disable iff (rst)
                        (busSel && busAddr >= OOR_BASE) |=> busErr);
  p_misalign_err_r5:  assert property (@(posedge clk) disable iff (rst)
                        (busSel && (busAddr[1:0] != 2'b00 || busSize != SIZE_WORD)) |=> busErr);
  p_dram_clear_r6:    assert property (@(posedge clk) disable iff (rst) !dramUpd);
  p_lock_needs_en_r8: assert property (@(posedge clk) disable iff (rst) (pllLock & ~pllEn) == '0);
  p_lock_drop_r8:     assert property (@(posedge clk) disable iff (rst)
                        (pllEn == '0) |-> (pllLock == '0));
endmodule

bind ccu_regblock ccu_regblock_chk #(.ADDR_W(ADDR_W), .OOR_BASE(OOR_BASE)) u_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busAddr(busAddr), .busSize(busSize),
  .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
  .pllEn(pllEn), .pllLock(pllLock), .dramUpd(dramUpd)
);

// File: tb/ccu_regblock_bench.sv
module ccu_regblock_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        busErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  bit started = 0;
  string curReq = "R9";

  ccu_regblock u_ccu_regblock (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .busErr(busErr)
  );

  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [31:0] mem [int];
  int          cntM [9];
  logic        expReady = 0, expErr = 0;
  logic [31:0] expRdata = 0;
  int pllAddr [9] = '{'h000, 'h008, 'h010, 'h018, 'h020, 'h028, 'h038, 'h044, 'h048};

  function automatic int pllOf(input int a);
    for (int p = 0; p < 9; p++) if (pllAddr[p] == a) return p;
    return -1;
  endfunction

  task automatic modelReset();  // R1 values
    mem.delete();
    mem['h000] = 32'h00001000; mem['h008] = 32'h00035514; mem['h010] = 32'h03006207;
    mem['h018] = 32'h03006207; mem['h020] = 32'h00001000; mem['h028] = 32'h00041811;
    mem['h038] = 32'h03006207; mem['h044] = 32'h00041811; mem['h048] = 32'h03006207;
    mem['h050] = 32'h00010000; mem['h054] = 32'h00001010; mem['h058] = 32'h01000000;
    mem['h0F4] = 32'h0;        mem['h0FC] = 32'h80000000;
    mem['h200] = 32'hFF;       mem['h204] = 32'hFF;
    for (int p = 0; p < 9; p++) mem[pllAddr[p] + 'h220] = 32'h10100000;
    mem['h220] = 32'h08100200; mem['h240] = 32'h81104000;
    mem['h248] = 32'h10100010; mem['h264] = 32'h10100010;
    mem['h250] = 32'h0A101000; mem['h260] = 32'h14880000;
    for (int p = 0; p < 9; p++) cntM[p] = 0;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      modelReset();
      expReady = 0; expErr = 0; expRdata = 0;
    end else begin
      int a;
      bit ok;
      a = int'(busAddr);
      ok = (busAddr[1:0] == 2'b00) && (busSize == 2'd2) && (a < 'h308);
      expReady = busSel; expErr = busSel && !ok; expRdata = 0;
      if (busSel && ok && !busWrite && mem.exists(a)) expRdata = mem[a];
      for (int p = 0; p < 9; p++) begin
        if (cntM[p] > 0) begin
          cntM[p]--;
          if (cntM[p] == 0) mem[pllAddr[p]][28] = 1'b1;
        end
      end
      if (busSel && ok && busWrite && mem.exists(a)) begin
        logic [31:0] v;
        int p;
        int d;
        v = busWdata;
        p = pllOf(a);
        if (p >= 0) begin
          if (!busWdata[31]) begin
            v[28] = 0; cntM[p] = 0;
          end else if (!mem[a][31]) begin
            d = (p < 5) ? int'(mem['h200][7:0]) : int'(mem['h204][7:0]);
            v[28] = (d == 0); cntM[p] = d;
          end else begin
            v[28] = mem[a][28];
          end
        end else if (a == 'h0F4) begin
          v[16] = 0;
        end
        mem[a] = v;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if ({busReady, busErr, busRdata} !== {expReady, expErr, expRdata}) begin
        bad++;
        $display("FAIL %s: got ready=%0b err=%0b data=%08h, expected ready=%0b err=%0b data=%08h",
                 curReq, busReady, busErr, busRdata, expReady, expErr, expRdata);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic w, input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = w; busAddr = a; busSize = sz; busWdata = d;
  endtask
  task automatic wr32(input logic [9:0] a, input logic [31:0] d); drive(1, a, 2'd2, d); endtask
  task automatic rd32(input logic [9:0] a); drive(0, a, 2'd2, 32'h0); endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); busSel = 0; busWrite = 0; end
  endtask
  task automatic readAll();
    foreach (pllAddr[p]) rd32(10'(pllAddr[p]));
    foreach (pllAddr[p]) rd32(10'(pllAddr[p] + 'h220));
    rd32('h050); rd32('h054); rd32('h058); rd32('h0F4); rd32('h0FC);
    rd32('h200); rd32('h204); rd32('h250); rd32('h260);
  endtask

  initial begin
    curReq = "R9"; idle(3);
    @(negedge clk); rst = 0;
    curReq = "R1"; readAll(); idle(2);

    curReq = "R2"; idle(3); rd32('h050); idle(1); wr32('h054, 32'h1234_5678); idle(2);

    curReq = "R3";
    wr32('h050, 32'hA5A5_5A5A); rd32('h050);
    wr32('h25C - 'h1C + 'h1C, 32'h0); // 0x25C: bias slot gap, unmapped
    wr32('h004, 32'hDEAD_BEEF); rd32('h004); rd32('h304); rd32('h260);
    wr32('h260, 32'hFFFF_FFFF); rd32('h260); idle(2);

    curReq = "R4";
    wr32('h310, 32'h1111_1111); rd32('h310); rd32('h308); rd32('h3FC);
    wr32('h308, 32'h2222_2222); rd32('h308); idle(2);

    curReq = "R5";
    drive(1, 10'h052, 2'd2, 32'hFFFF_FFFF); drive(1, 10'h050, 2'd1, 32'h0);
    drive(1, 10'h050, 2'd0, 32'h0); drive(0, 10'h051, 2'd2, 32'h0);
    drive(1, 10'h050, 2'd3, 32'h0); rd32('h050); idle(2);

    curReq = "R6";
    wr32('h0F4, 32'hFFFF_FFFF); rd32('h0F4); wr32('h0F4, 32'h0001_0003); rd32('h0F4); idle(2);

    curReq = "R7";
    wr32('h200, 32'h5); wr32('h000, 32'h8000_0000);
    repeat (8) rd32('h000);
    wr32('h204, 32'h0); wr32('h028, 32'h8000_0123); rd32('h028);
    wr32('h008, 32'h8003_5514);  // settle word 0x200 now 5
    repeat (7) rd32('h008);
    idle(2);

    curReq = "R8";
    wr32('h000, 32'h0000_0000); rd32('h000);
    wr32('h010, 32'h1000_0000); rd32('h010);
    wr32('h200, 32'hA); wr32('h018, 32'h8000_0000); idle(4);
    wr32('h018, 32'h9000_0001); repeat (8) rd32('h018);
    wr32('h018, 32'h8000_0002); rd32('h018); idle(2);

    curReq = "R7";
    @(negedge clk); rst = 1; busSel = 0; @(negedge clk); rst = 0;
    wr32('h048, 32'h8000_0000); idle(250); repeat (8) rd32('h048);
    wr32('h020, 32'h8000_0000); idle(20);

    curReq = "R9";
    @(negedge clk); rst = 1; busSel = 0; @(negedge clk); rst = 0;
    readAll(); idle(300); rd32('h020); idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule